// File: doc/BRIEF.md
# Pointer-Aliased Data Memory Front End

This block sits between a processor core's data-memory port and a byte-wide data RAM. Two addresses in the low end of the map hold no storage. Each one stands in for the RAM location named by its own 8-bit pointer register. Each pointer sits at the address just above its alias. The front end holds both pointers and decodes each core access. It then either steers the access to the RAM, serves it from a pointer register, or swallows it. An access is swallowed when a pointer names one of the two alias addresses.

The core side has one access per cycle: an enable, a write strobe, an address and write data. Read data comes back one cycle later and stays put until the next read. The RAM side drives an enable, a write strobe, an address and write data in the same cycle as the core request. It expects the RAM to return read data on the following edge. Every address from 04H upward passes to the RAM unchanged.

Top module: `ptr_alias_frontend`

## Requirements
- R1: After reset both pointers hold 00H, and the read-data output shows 00H until the first read completes.
- R2: A core access to any address of 04H or above drives the RAM enable with that same address, the RAM write strobe equal to the core write strobe, and the core write data.
- R3: Addresses 01H (first pointer) and 03H (second pointer) read and write the pointer registers like ordinary locations, and never enable the RAM.
- R4: An access to 00H is redirected to the address held in the first pointer, and an access to 02H to the address held in the second pointer, for both reads and writes.
- R5: A read through a pointer that holds 00H or 02H returns 00H and does not enable the RAM.
- R6: A write through a pointer that holds 00H or 02H changes neither pointer and does not enable the RAM.
- R7: A pointer holding 01H or 03H makes the indirect access reach that pointer register, both for reads and for writes.
- R8: Read data appears on the core read bus in the cycle after the read request. It holds its value through idle cycles and writes until the next read completes.
- R9: A pointer write takes effect on the same edge, so an indirect access in the very next cycle uses the new pointer value.
- R10: With the core enable low, the RAM enable and write strobe stay low and neither pointer changes, whatever the other core inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_en | input | 1 | Core access request this cycle |
| acc_we | input | 1 | Core access is a write when high |
| acc_addr | input | 8 | Core byte address |
| acc_wdata | input | 8 | Core write data |
| acc_rdata | output | 8 | Core read data, valid the cycle after a read |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 8 | Effective RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one cycle after the enable |

## Verification
A pointer update and an indirect access that depends on it can fall in back-to-back cycles. A write through one alias can also land on a pointer register, which makes the alias decode and the pointer update act on the same edge. The bench provokes this in two ways. It writes a pointer and then touches its alias in the very next cycle, and it writes through the second alias while the second pointer aims at the first pointer. The RAM address driven in the following cycle and the data later read back are compared with values worked out from the pointer contents the requirements predict.

// File: rtl/ptr_alias_pkg.sv
`timescale 1ns/1ps
package ptr_alias_pkg;

    localparam int unsigned PA_AW   = 8;
    localparam int unsigned PA_DW   = 8;
    localparam int unsigned PA_NPTR = 2;

    // Where the read data of a completed read is taken from.
    typedef enum logic {
        SRC_LOCAL = 1'b0,
        SRC_RAM   = 1'b1
    } rd_src_e;

    // Alias k sits at an even address, its pointer right above it.
    function automatic int unsigned alias_loc(input int unsigned k);
        return 2 * k;
    endfunction

    function automatic int unsigned ptr_loc(input int unsigned k);
        return 2 * k + 1;
    endfunction

endpackage

// File: rtl/alias_decode.sv
`timescale 1ns/1ps
module alias_decode
    import ptr_alias_pkg::*;
#(
    parameter int unsigned AW   = PA_AW,
    parameter int unsigned NPTR = PA_NPTR,
    parameter int unsigned IW   = (NPTR > 1) ? $clog2(NPTR) : 1
) (
    input  logic [AW-1:0]      addr,
    input  logic [NPTR*AW-1:0] ptr_flat,
    output logic               ram_sel,
    output logic [AW-1:0]      eff_addr,
    output logic               ptr_sel,
    output logic [IW-1:0]      ptr_idx,
    output logic               null_sel
);

    localparam int unsigned SPECIAL_TOP = 2 * NPTR;

    logic [AW-1:0] eff;

    // Stage 1: replace an alias address by its pointer content.
    always_comb begin
        eff = addr;
        for (int k = 0; k < NPTR; k++) begin
            if (addr == AW'(alias_loc(k))) begin
                eff = ptr_flat[k*AW +: AW];
            end
        end
    end

    // Stage 2: classify the effective address.
    always_comb begin
        ptr_sel  = 1'b0;
        ptr_idx  = '0;
        null_sel = 1'b0;
        for (int k = 0; k < NPTR; k++) begin
            if (eff == AW'(ptr_loc(k))) begin
                ptr_sel = 1'b1;
                ptr_idx = IW'(k);
            end
            if (eff == AW'(alias_loc(k))) begin
                null_sel = 1'b1;
            end
        end
        ram_sel  = !ptr_sel && !null_sel;
        eff_addr = eff;
    end

    initial begin
        if (SPECIAL_TOP > (1 << AW)) begin
            $error("alias_decode: special locations exceed address space");
        end
    end

endmodule

// File: rtl/ptr_bank.sv
`timescale 1ns/1ps
module ptr_bank
    import ptr_alias_pkg::*;
#(
    parameter int unsigned AW   = PA_AW,
    parameter int unsigned NPTR = PA_NPTR,
    parameter int unsigned IW   = (NPTR > 1) ? $clog2(NPTR) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IW-1:0]      wr_idx,
    input  logic [AW-1:0]      wr_data,
    output logic [NPTR*AW-1:0] ptr_flat
);

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        logic [AW-1:0] ptr_d;
        logic [AW-1:0] ptr_q;

        always_comb begin
            ptr_d = ptr_q;
            if (wr_en && (wr_idx == IW'(g))) begin
                ptr_d = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ptr_q <= '0;
            end else begin
                ptr_q <= ptr_d;
            end
        end

        assign ptr_flat[g*AW +: AW] = ptr_q;
    end

endmodule

// File: rtl/rd_return.sv
`timescale 1ns/1ps
module rd_return
    import ptr_alias_pkg::*;
#(
    parameter int unsigned DW = PA_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  rd_src_e       cap_src,
    input  logic [DW-1:0] cap_val,
    input  logic [DW-1:0] ram_rdata,
    output logic [DW-1:0] rdata
);

    typedef struct packed {
        rd_src_e       src;
        logic [DW-1:0] val;
    } ret_t;

    ret_t st_d;
    ret_t st_q;

    always_comb begin
        st_d = st_q;
        if (capture) begin
            st_d.src = cap_src;
            st_d.val = cap_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{src: SRC_LOCAL, val: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // The RAM keeps its output between reads, so selecting it holds the value.
    assign rdata = (st_q.src == SRC_RAM) ? ram_rdata : st_q.val;

endmodule

// File: rtl/ptr_alias_frontend.sv
`timescale 1ns/1ps
module ptr_alias_frontend
    import ptr_alias_pkg::*;
#(
    parameter int unsigned AW   = PA_AW,
    parameter int unsigned DW   = PA_DW,
    parameter int unsigned NPTR = PA_NPTR
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_en,
    input  logic          acc_we,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_wdata,
    output logic [DW-1:0] acc_rdata,
    output logic          ram_en,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata,
    input  logic [DW-1:0] ram_rdata
);

    localparam int unsigned IW = (NPTR > 1) ? $clog2(NPTR) : 1;

    logic [NPTR*AW-1:0] ptr_flat;
    logic               dec_ram;
    logic [AW-1:0]      dec_addr;
    logic               dec_ptr;
    logic [IW-1:0]      dec_idx;
    logic               dec_null;
    logic               ptr_wr;
    logic [AW-1:0]      ptr_wval;
    logic               rd_cap;
    rd_src_e            rd_src;
    logic [DW-1:0]      rd_val;
    logic [AW-1:0]      ptr_sel_val;

    alias_decode #(.AW(AW), .NPTR(NPTR), .IW(IW)) i_decode (
        .addr     (acc_addr),
        .ptr_flat (ptr_flat),
        .ram_sel  (dec_ram),
        .eff_addr (dec_addr),
        .ptr_sel  (dec_ptr),
        .ptr_idx  (dec_idx),
        .null_sel (dec_null)
    );

    ptr_bank #(.AW(AW), .NPTR(NPTR), .IW(IW)) i_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ptr_wr),
        .wr_idx   (dec_idx),
        .wr_data  (ptr_wval),
        .ptr_flat (ptr_flat)
    );

    rd_return #(.DW(DW)) i_ret (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (rd_cap),
        .cap_src   (rd_src),
        .cap_val   (rd_val),
        .ram_rdata (ram_rdata),
        .rdata     (acc_rdata)
    );

    always_comb begin
        // RAM side: only plain RAM locations reach it.
        ram_en    = acc_en && dec_ram;
        ram_we    = acc_en && dec_ram && acc_we;
        ram_addr  = dec_addr;
        ram_wdata = acc_wdata;

        // Pointer writes, direct or through an alias.
        ptr_wr   = acc_en && acc_we && dec_ptr;
        ptr_wval = AW'(acc_wdata);

        // Read return: pointer value, zero for a self-referencing alias, or RAM.
        ptr_sel_val = ptr_flat[dec_idx*AW +: AW];
        rd_cap      = acc_en && !acc_we;
        rd_src      = dec_ram ? SRC_RAM : SRC_LOCAL;
        rd_val      = dec_ptr ? DW'(ptr_sel_val) : '0;
        if (dec_null) begin
            rd_val = '0;
        end
    end

endmodule

// File: rtl/ptr_alias_checker.sv
`timescale 1ns/1ps
module ptr_alias_checker
    import ptr_alias_pkg::*;
#(
    parameter int unsigned AW   = PA_AW,
    parameter int unsigned DW   = PA_DW,
    parameter int unsigned NPTR = PA_NPTR
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acc_en,
    input logic               acc_we,
    input logic [AW-1:0]      acc_addr,
    input logic [DW-1:0]      acc_wdata,
    input logic [DW-1:0]      acc_rdata,
    input logic               ram_en,
    input logic               ram_we,
    input logic [AW-1:0]      ram_addr,
    input logic [NPTR*AW-1:0] ptr_flat
);

    localparam logic [AW-1:0] TOP = AW'(2 * NPTR);

    assert_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_addr >= TOP) |-> (ram_en && ram_addr == acc_addr && ram_we == acc_we));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |-> (!ram_en && !ram_we));

    assert_idle_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> (ptr_flat == $past(ptr_flat)));

    for (genvar g = 0; g < NPTR; g++) begin : g_chk
        logic [AW-1:0] pv;
        logic          pv_self;
        assign pv      = ptr_flat[g*AW +: AW];
        assign pv_self = (pv < TOP) && !pv[0];

        assert_ptr_no_ram_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_en && acc_addr == AW'(ptr_loc(g))) |-> !ram_en);

        assert_ptr_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_en && acc_we && acc_addr == AW'(ptr_loc(g))) |=> (pv == AW'($past(acc_wdata))));

        assert_redirect_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_en && acc_addr == AW'(alias_loc(g)) && pv >= TOP) |-> (ram_en && ram_addr == pv));

        assert_self_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_en && !acc_we && acc_addr == AW'(alias_loc(g)) && pv_self) |=> (acc_rdata == '0));

        assert_self_write_no_ram_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_en && acc_we && acc_addr == AW'(alias_loc(g)) && pv_self) |-> !ram_en);

        assert_self_write_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_en && acc_we && acc_addr == AW'(alias_loc(g)) && pv_self) |=> (ptr_flat == $past(ptr_flat)));
    end

endmodule

bind ptr_alias_frontend ptr_alias_checker #(.AW(AW), .DW(DW), .NPTR(NPTR)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (acc_en),
    .acc_we    (acc_we),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .acc_rdata (acc_rdata),
    .ram_en    (ram_en),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ptr_flat  (ptr_flat)
);

// File: tb/test_ptr_alias_frontend.sv
`timescale 1ns/1ps
module test_ptr_alias_frontend;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_en = 1'b0;
    logic       acc_we = 1'b0;
    logic [7:0] acc_addr = '0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] acc_rdata;
    logic       ram_en;
    logic       ram_we;
    logic [7:0] ram_addr;
    logic [7:0] ram_wdata;
    logic [7:0] ram_rdata = '0;

    int vec = 0;
    int bad = 0;
    logic       s_en;
    logic       s_we;
    logic [7:0] s_addr;
    logic [7:0] s_prev;
    logic [7:0] rv;

    logic [7:0] mem [256];

    always #2 clk = ~clk;

    ptr_alias_frontend i_ptr_alias_frontend (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    // Behavioural RAM: synchronous, output held between reads.
    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we) mem[ram_addr] <= ram_wdata;
            else        ram_rdata <= mem[ram_addr];
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b1; acc_addr = a; acc_wdata = d;
        #1;
        s_en = ram_en; s_we = ram_we; s_addr = ram_addr;
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b0; acc_addr = a;
        #1;
        s_en = ram_en; s_we = ram_we; s_addr = ram_addr; s_prev = acc_rdata;
        @(negedge clk);
        acc_en = 1'b0;
        #1;
        d = acc_rdata;
    endtask

    task automatic t_reset();
        chk("R1 rdata after reset", acc_rdata, 8'h00);
        rd(8'h01, rv); chk("R1 first pointer", rv, 8'h00);
        rd(8'h03, rv); chk("R1 second pointer", rv, 8'h00);
    endtask

    task automatic t_passthru();
        wr(8'h40, 8'hA5);
        chk("R2 en", {7'd0, s_en}, 8'h01); chk("R2 we", {7'd0, s_we}, 8'h01);
        chk("R2 addr", s_addr, 8'h40);
        wr(8'hFF, 8'h3E); chk("R2 addr top", s_addr, 8'hFF);
        wr(8'h04, 8'h19); chk("R2 addr lowest", s_addr, 8'h04);
        rd(8'h40, rv); chk("R2 read 40", rv, 8'hA5); chk("R2 rd we", {7'd0, s_we}, 8'h00);
        rd(8'hFF, rv); chk("R2 read FF", rv, 8'h3E);
        rd(8'h04, rv); chk("R2 read 04", rv, 8'h19);
    endtask

    task automatic t_ptrs();
        wr(8'h01, 8'h55); chk("R3 no ram on ptr0 write", {7'd0, s_en}, 8'h00);
        wr(8'h03, 8'h66); chk("R3 no ram on ptr1 write", {7'd0, s_en}, 8'h00);
        rd(8'h01, rv); chk("R3 ptr0 read", rv, 8'h55); chk("R3 no ram on read", {7'd0, s_en}, 8'h00);
        rd(8'h03, rv); chk("R3 ptr1 read", rv, 8'h66);
    endtask

    task automatic t_indirect();
        wr(8'h01, 8'h40);
        rd(8'h00, rv); chk("R4 alias0 read", rv, 8'hA5); chk("R4 alias0 addr", s_addr, 8'h40);
        wr(8'h03, 8'hFF);
        rd(8'h02, rv); chk("R4 alias1 read", rv, 8'h3E); chk("R4 alias1 addr", s_addr, 8'hFF);
        wr(8'h00, 8'h7C); rd(8'h40, rv); chk("R4 alias0 write", rv, 8'h7C);
        wr(8'h02, 8'hC3); rd(8'hFF, rv); chk("R4 alias1 write", rv, 8'hC3);
    endtask

    task automatic t_self_read();
        wr(8'h01, 8'h00);
        rd(8'h40, rv);
        rd(8'h00, rv); chk("R5 ptr0=00 read", rv, 8'h00); chk("R5 no ram", {7'd0, s_en}, 8'h00);
        wr(8'h01, 8'h02);
        rd(8'h40, rv);
        rd(8'h00, rv); chk("R5 ptr0=02 read", rv, 8'h00);
        wr(8'h03, 8'h00);
        rd(8'hFF, rv);
        rd(8'h02, rv); chk("R5 ptr1=00 read", rv, 8'h00);
    endtask

    task automatic t_self_write();
        wr(8'h01, 8'h02); wr(8'h03, 8'h00);
        wr(8'h00, 8'hEE); chk("R6 no ram alias0", {7'd0, s_en}, 8'h00);
        wr(8'h02, 8'hDD); chk("R6 no ram alias1", {7'd0, s_en}, 8'h00);
        rd(8'h01, rv); chk("R6 ptr0 kept", rv, 8'h02);
        rd(8'h03, rv); chk("R6 ptr1 kept", rv, 8'h00);
        rd(8'h40, rv); chk("R6 ram 40 kept", rv, 8'h7C);
        rd(8'hFF, rv); chk("R6 ram FF kept", rv, 8'hC3);
    endtask

    task automatic t_chain();
        wr(8'h03, 8'h01);
        wr(8'h02, 8'h90); chk("R7 no ram", {7'd0, s_en}, 8'h00);
        rd(8'h01, rv); chk("R7 ptr0 via alias1", rv, 8'h90);
        rd(8'h02, rv); chk("R7 read ptr0 via alias1", rv, 8'h90);
        wr(8'h03, 8'h03);
        rd(8'h02, rv); chk("R7 alias1 reads ptr1", rv, 8'h03);
        wr(8'h02, 8'h04);
        rd(8'h03, rv); chk("R7 ptr1 via itself", rv, 8'h04);
    endtask

    task automatic t_hold();
        rd(8'h01, rv); chk("R8 ptr read", rv, 8'h90);
        rd(8'h40, rv); chk("R8 old data in request cycle", s_prev, 8'h90);
        chk("R8 new data next cycle", rv, 8'h7C);
        repeat (3) @(negedge clk);
        chk("R8 hold idle", acc_rdata, 8'h7C);
        wr(8'h05, 8'h11); #1; chk("R8 hold over ram write", acc_rdata, 8'h7C);
        rd(8'h01, rv);
        wr(8'h01, 8'h12); #1; chk("R8 hold over ptr write", acc_rdata, 8'h90);
    endtask

    task automatic t_b2b();
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b1; acc_addr = 8'h01; acc_wdata = 8'h40;
        @(negedge clk);
        acc_we = 1'b0; acc_addr = 8'h00;
        #1; chk("R9 next-cycle addr", ram_addr, 8'h40); chk("R9 ram en", {7'd0, ram_en}, 8'h01);
        @(negedge clk);
        acc_en = 1'b0;
        #1; chk("R9 next-cycle data", acc_rdata, 8'h7C);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b1; acc_addr = 8'h03; acc_wdata = 8'hFF;
        @(negedge clk);
        acc_addr = 8'h02; acc_wdata = 8'h5A;
        #1; chk("R9 alias1 write addr", ram_addr, 8'hFF); chk("R9 alias1 we", {7'd0, ram_we}, 8'h01);
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0;
        rd(8'hFF, rv); chk("R9 alias1 data", rv, 8'h5A);
    endtask

    task automatic t_idle();
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b1; acc_addr = 8'h01; acc_wdata = 8'hAB;
        #1; chk("R10 ram en low", {7'd0, ram_en}, 8'h00); chk("R10 ram we low", {7'd0, ram_we}, 8'h00);
        @(negedge clk);
        acc_addr = 8'h40;
        #1; chk("R10 ram en low at 40", {7'd0, ram_en}, 8'h00);
        @(negedge clk);
        acc_we = 1'b0;
        rd(8'h01, rv); chk("R10 ptr0 unchanged", rv, 8'h40);
        rd(8'h40, rv); chk("R10 ram unchanged", rv, 8'h7C);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_passthru();
        t_ptrs();
        t_indirect();
        t_self_read();
        t_self_write();
        t_chain();
        t_hold();
        t_b2b();
        t_idle();
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        vec++; bad++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

endmodule